// File: doc/BRIEF.md
# Interprocessor Semaphore Switch Bank

A bank of single-bit semaphore switches shared between processors. A small register window on a synchronous slave bus reaches them. Each switch has two write addresses, one that sets it and one that clears it. The address alone selects the action, and the write data is ignored. Switches come in two kinds:

- **Module switches** can be written on any cycle. Each one drives an interrupt line toward the local host. A per-switch mask bit can silence that line.
- **Global switches** change only on privileged cycles.

The same window also holds five byte-wide mailbox registers and a mask register. It also holds a status byte that shows every switch. The status byte is visible only when the access comes from the local host.

Reads are combinational from the current address. A write takes effect at the next rising clock edge.

Top module: `ipc_semaphore_bank`

## Requirements
- R1: During and after reset, all switches, mask bits and mailboxes are zero, and every irq_o bit is low.
- R2: A write to offset 9+2k sets module switch k, and a write to offset 17+2k sets global switch k, whatever the data. A switch write changes no mailbox or mask.
- R3: A write to offset 8+2k clears module switch k, and a write to offset 16+2k clears global switch k, whatever the data.
- R4: A set or clear of a global switch takes effect only when priv_i is high. Without priv_i it leaves the switch unchanged.
- R5: A set or clear of a module switch takes effect whether priv_i is high or low.
- R6: irq_o[k] is high exactly while module switch k is set and mask bit k is clear. It changes only after a write.
- R7: Offsets 0 to 4 are five independent byte mailboxes. Each returns the last byte written to it.
- R8: The status byte at offset 6 holds module switch k in bit k and global switch k in bit 4+k. It reads as zero when local_i is low.
- R9: The mask register at offset 5 holds module-switch mask bit k in bit k. Its bits 7:4 read as zero.
- R10: A read of offset 7 or of any offset from 8 to 31 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the current address |
| priv_i | input | 1 | Access is privileged |
| local_i | input | 1 | Access comes from the local host |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 4 | Per module switch interrupt request |

## Verification
The bench builds the block with its default parameters: four module switches, four global switches and five mailboxes. With these values every offset of the 32-entry window is populated or deliberately empty. Every set and clear address, the privilege gate, the mask and the hidden status byte can all be reached.

The test runs a vector table that walks the switch states through set, clear and masked combinations under both privilege levels. After that come directed checks for:
- the reset values;
- unmapped reads;
- a reset applied mid-run.

// File: rtl/ipc_sem_pkg.sv
package ipc_sem_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int MBOX_BASE = 0;
  localparam int MASK_ADDR = 5;
  localparam int STAT_ADDR = 6;
  localparam int MOD_BASE  = 8;
  localparam int GLB_BASE  = 16;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/ipc_sem_decode.sv
module ipc_sem_decode
  import ipc_sem_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int NUM_GLB  = 4,
  parameter int NUM_MBOX = 5
) (
  input  logic                wr_i,
  input  logic                priv_i,
  input  addr_t               addr_i,
  output logic [NUM_MOD-1:0]  mod_set_o,
  output logic [NUM_MOD-1:0]  mod_clr_o,
  output logic [NUM_GLB-1:0]  glb_set_o,
  output logic [NUM_GLB-1:0]  glb_clr_o,
  output logic [NUM_MBOX-1:0] mbox_we_o,
  output logic                mask_we_o
);
  for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
    assign mod_clr_o[k] = wr_i && (addr_i == addr_t'(MOD_BASE + 2*k));
    assign mod_set_o[k] = wr_i && (addr_i == addr_t'(MOD_BASE + 2*k + 1));
  end

  // global switches are gated by privilege
  for (genvar k = 0; k < NUM_GLB; k++) begin : g_glb
    assign glb_clr_o[k] = wr_i && priv_i && (addr_i == addr_t'(GLB_BASE + 2*k));
    assign glb_set_o[k] = wr_i && priv_i && (addr_i == addr_t'(GLB_BASE + 2*k + 1));
  end

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    assign mbox_we_o[m] = wr_i && (addr_i == addr_t'(MBOX_BASE + m));
  end

  assign mask_we_o = wr_i && (addr_i == addr_t'(MASK_ADDR));
endmodule

// File: rtl/ipc_sem_switch.sv
module ipc_sem_switch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;  // clear has priority
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/ipc_sem_mbox.sv
module ipc_sem_mbox
  import ipc_sem_pkg::*;
#(
  parameter int NUM_MBOX = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_MBOX-1:0]           we_i,
  input  data_t                         wdata_i,
  output logic [NUM_MBOX-1:0][DATA_W-1:0] q_o
);
  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[m] <= '0;
      else if (we_i[m]) q_o[m] <= wdata_i;
    end
  end
endmodule

// File: rtl/ipc_semaphore_bank.sv
module ipc_semaphore_bank
  import ipc_sem_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int NUM_GLB  = 4,
  parameter int NUM_MBOX = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               priv_i,
  input  logic               local_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_MOD-1:0] irq_o
);
  localparam int STAT_W = NUM_MOD + NUM_GLB;

  logic [NUM_MOD-1:0]  mod_set, mod_clr, mod_q, mask_q;
  logic [NUM_GLB-1:0]  glb_set, glb_clr, glb_q;
  logic [NUM_MBOX-1:0] mbox_we;
  logic                mask_we;
  logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_q;
  logic [STAT_W-1:0]   stat_bits;

  ipc_sem_decode #(.NUM_MOD(NUM_MOD), .NUM_GLB(NUM_GLB), .NUM_MBOX(NUM_MBOX)) u_dec (
    .wr_i     (wr_i),
    .priv_i   (priv_i),
    .addr_i   (addr_i),
    .mod_set_o(mod_set),
    .mod_clr_o(mod_clr),
    .glb_set_o(glb_set),
    .glb_clr_o(glb_clr),
    .mbox_we_o(mbox_we),
    .mask_we_o(mask_we)
  );

  for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
    ipc_sem_switch u_sw (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (mod_set[k]),
      .clr_i (mod_clr[k]),
      .q_o   (mod_q[k])
    );
  end

  for (genvar k = 0; k < NUM_GLB; k++) begin : g_glb
    ipc_sem_switch u_sw (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (glb_set[k]),
      .clr_i (glb_clr[k]),
      .q_o   (glb_q[k])
    );
  end

  ipc_sem_mbox #(.NUM_MBOX(NUM_MBOX)) u_mbox (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mbox_we),
    .wdata_i(wdata_i),
    .q_o    (mbox_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= wdata_i[NUM_MOD-1:0];
  end

  assign irq_o     = mod_q & ~mask_q;
  assign stat_bits = {glb_q, mod_q};

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < MBOX_BASE + NUM_MBOX) begin
      rdata_o = mbox_q[int'(addr_i) - MBOX_BASE];
    end else if (addr_i == addr_t'(MASK_ADDR)) begin
      rdata_o = DATA_W'(mask_q);
    end else if (addr_i == addr_t'(STAT_ADDR) && local_i) begin
      rdata_o = DATA_W'(stat_bits);
    end
  end
endmodule

// File: rtl/ipc_semaphore_bank_chk.sv
module ipc_semaphore_bank_chk
  import ipc_sem_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int NUM_GLB = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               priv_i,
  input logic               local_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_MOD-1:0] irq_o,
  input logic [NUM_MOD-1:0] mod_q,
  input logic [NUM_GLB-1:0] glb_q
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0) && (mod_q == '0) && (glb_q == '0)); // R1

  for (genvar k = 0; k < NUM_MOD; k++) begin : g_mod
    AST_MOD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == addr_t'(MOD_BASE + 2*k + 1) |=> mod_q[k]); // R2
    AST_MOD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == addr_t'(MOD_BASE + 2*k) |=> !mod_q[k]); // R3
    AST_IRQ_NEEDS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] |-> mod_q[k]); // R6
  end

  for (genvar k = 0; k < NUM_GLB; k++) begin : g_glb
    AST_GLB_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && priv_i && addr_i == addr_t'(GLB_BASE + 2*k + 1) |=> glb_q[k]); // R4
  end

  AST_GLB_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !priv_i |=> $stable(glb_q)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mod_q) && $stable(glb_q) && $stable(irq_o)); // R6

  AST_STAT_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == addr_t'(STAT_ADDR) && !local_i |-> rdata_o == '0); // R8
endmodule

bind ipc_semaphore_bank ipc_semaphore_bank_chk #(.NUM_MOD(NUM_MOD), .NUM_GLB(NUM_GLB)) u_chk (.*);

// File: tb/ipc_semaphore_bank_tb.sv
module ipc_semaphore_bank_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       wr_i = 1'b0, priv_i = 1'b0, local_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ipc_semaphore_bank u_dut (.*);

  // {wr, priv, addr, wdata, raddr, local, exp_rdata, exp_irq, req}
  localparam int NV = 18;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1,1'b0,5'd9 ,8'h00, 5'd6,1'b1,8'h01,4'h1,4'd2},  // R2 set mod0
    {1'b1,1'b0,5'd13,8'hFF, 5'd6,1'b1,8'h05,4'h5,4'd2},  // R2 set mod2
    {1'b1,1'b0,5'd8 ,8'hFF, 5'd6,1'b1,8'h04,4'h4,4'd3},  // R3 clr mod0
    {1'b1,1'b0,5'd19,8'h00, 5'd6,1'b1,8'h04,4'h4,4'd4},  // R4 unpriv set glb1
    {1'b1,1'b1,5'd19,8'h00, 5'd6,1'b1,8'h24,4'h4,4'd4},  // R4 priv set glb1
    {1'b1,1'b0,5'd18,8'h00, 5'd6,1'b1,8'h24,4'h4,4'd4},  // R4 unpriv clr glb1
    {1'b1,1'b0,5'd15,8'h00, 5'd6,1'b1,8'h2C,4'hC,4'd5},  // R5 set mod3 unpriv
    {1'b1,1'b0,5'd5 ,8'hF4, 5'd5,1'b1,8'h04,4'h8,4'd9},  // R9 mask bit2
    {1'b1,1'b1,5'd23,8'h00, 5'd6,1'b1,8'hAC,4'h8,4'd4},  // R4 priv set glb3
    {1'b0,1'b0,5'd6 ,8'h00, 5'd6,1'b0,8'h00,4'h8,4'd8},  // R8 hidden status
    {1'b1,1'b0,5'd0 ,8'h5A, 5'd0,1'b0,8'h5A,4'h8,4'd7},  // R7 mbox0
    {1'b1,1'b0,5'd4 ,8'hC3, 5'd4,1'b0,8'hC3,4'h8,4'd7},  // R7 mbox4
    {1'b0,1'b0,5'd0 ,8'h00, 5'd0,1'b0,8'h5A,4'h8,4'd7},  // R7 mbox0 kept
    {1'b1,1'b1,5'd18,8'hAA, 5'd6,1'b1,8'h8C,4'h8,4'd3},  // R3 priv clr glb1
    {1'b1,1'b1,5'd5 ,8'h00, 5'd6,1'b1,8'h8C,4'hC,4'd6},  // R6 unmask
    {1'b1,1'b0,5'd9 ,8'h77, 5'd0,1'b1,8'h5A,4'hD,4'd2},  // R2 switch write spares mbox
    {1'b0,1'b0,5'd6 ,8'h00, 5'd6,1'b1,8'h8D,4'hD,4'd2},  // R2 status after set
    {1'b0,1'b0,5'd9 ,8'h00, 5'd9,1'b1,8'h00,4'hD,4'd10}  // R10 switch addr reads 0
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic p, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = w; priv_i = p; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic l);
    addr_i = a; local_i = l;
    #1;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #12 rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk_i);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a), 1'b1);
      check8("R1", rdata_o, 8'h00);
    end
    check8("R1", {4'h0, irq_o}, 8'h00);

    foreach (VEC[i]) begin
      logic [36:0] v;
      v = VEC[i];
      if (v[36]) op(1'b1, v[35], v[34:30], v[29:22]);
      else @(negedge clk_i);
      rd(v[21:17], v[16]);
      check8($sformatf("R%0d vec%0d rdata", v[3:0], i), rdata_o, v[15:8]);
      check8($sformatf("R%0d vec%0d irq", v[3:0], i), {4'h0, irq_o}, {4'h0, v[7:4]});
    end

    // R10 unmapped offsets
    rd(5'd7, 1'b1);  check8("R10", rdata_o, 8'h00);
    rd(5'd31, 1'b1); check8("R10", rdata_o, 8'h00);
    // R6 masked switch silences only its own line
    op(1'b1, 1'b0, 5'd5, 8'h01);
    check8("R6", {4'h0, irq_o}, 8'h0C);
    // R1 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    rd(5'd6, 1'b1); check8("R1", rdata_o, 8'h00);
    rd(5'd0, 1'b1); check8("R1", rdata_o, 8'h00);
    rd(5'd5, 1'b1); check8("R1", rdata_o, 8'h00);
    check8("R1", {4'h0, irq_o}, 8'h00);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule